// File: doc/BRIEF.md
# Double-Buffered Byte-Bus DAC Register Front End

This block is the register front end for an analog output module carrying one or two 16-bit converter channels behind an 8-bit write bus. Each channel owns two staging bytes (low and high) that software fills one at a time. Filling them has no effect on the converter. Only a strobe write copies the assembled 16-bit two's-complement word into the channel's output latch, which drives the converter's parallel input. On the same edge the strobe raises a one-cycle load pulse for that channel.

A per-channel strobe updates one channel. A shared strobe address updates every present channel on the same edge, so two outputs can change together. Software writes the low byte, then the high byte, then a strobe. An identification byte at address 0x00 tells software whether the one-channel or the two-channel build is fitted. The build is chosen with the `NUM_CH` parameter. In the one-channel build, every channel-1 address is dead.

Top module: `dac_stage_regs`

## Requirements
- R1: Reading address 0x00 returns 0xE3 when NUM_CH is 2 and 0xE2 when NUM_CH is 1. Every other address reads 0x00. The read data follows `bus_addr` combinationally.
- R2: Channel c (c = 0 or 1) is addressed as follows: low staging byte at 0x0D + 8c, high staging byte at 0x0E + 8c, strobe at 0x0B + 8c. Channel c's latched word appears on `dac_word[16c+15:16c]`, and its load pulse appears on `dac_load[c]`.
- R3: Writing a staging byte never changes `dac_word`.
- R4: A strobe write sampled at a rising edge does two things from that edge on: it sets the channel's word to {high byte, low byte}, and it drives that channel's `dac_load` high for exactly one cycle.
- R5: A write to 0x1B strobes all present channels on the same edge.
- R6: The data byte carried by any strobe write is ignored.
- R7: With NUM_CH = 1, writes to 0x13, 0x15 and 0x16 change neither the channel-0 staging bytes nor any output. A write to 0x1B loads channel 0.
- R8: After reset, every latched word is 0x0000, every staging byte is 0x00, and `dac_load` is low.
- R9: A repeated strobe with no new staging writes reloads the same word and pulses `dac_load` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write enable, sampled on the rising edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (identification byte at 0x00) |
| dac_word | output | 16*NUM_CH | Latched converter words, channel c at bits [16c+15:16c] |
| dac_load | output | NUM_CH | One-cycle load pulse per channel |

## Verification
Two events can fall in the same cycle: the load pulse left by a strobe, and the next bus write to a staging byte. The bench provokes this by issuing a high-byte write in the cycle directly after a strobe. It checks that the pulse still ends after one cycle and that the latched word keeps the value it took at the strobe. A following shared strobe must then show the new byte. A one-channel instance sits on the same bus for the whole run. Its word and pulse are compared at each step, which shows that channel-1 traffic never reaches it.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam logic [BYTE_W-1:0] ID_ADDR   = 8'h00;
  localparam logic [BYTE_W-1:0] BOTH_ADDR = 8'h1B;

  // per-channel address helpers: each channel occupies an 8-byte window
  function automatic logic [BYTE_W-1:0] strobe_addr(input int ch);
    return BYTE_W'(11 + 8 * ch);
  endfunction

  function automatic logic [BYTE_W-1:0] lo_addr(input int ch);
    return BYTE_W'(13 + 8 * ch);
  endfunction

  function automatic logic [BYTE_W-1:0] hi_addr(input int ch);
    return BYTE_W'(14 + 8 * ch);
  endfunction

  // identification byte depends on the number of fitted channels
  function automatic logic [BYTE_W-1:0] id_code(input int n_ch);
    return (n_ch >= 2) ? 8'hE3 : 8'hE2;
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_addr,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic [NUM_CH-1:0] ld_req
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign lo_we[c]  = bus_wr && (bus_addr == lo_addr(c));
    assign hi_we[c]  = bus_wr && (bus_addr == hi_addr(c));
    assign ld_req[c] = bus_wr && ((bus_addr == strobe_addr(c)) ||
                                  (bus_addr == BOTH_ADDR));

    // R2: one bus write selects at most one function of a channel
    p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_we[c], hi_we[c], ld_req[c]}));
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              ld_req,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output logic              load
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  // staging bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= wdata;
      if (hi_we) hi_q <= wdata;
    end
  end

  // output latch and load pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      load <= 1'b0;
    end else begin
      load <= ld_req;
      if (ld_req) word <= {hi_q, lo_q};
    end
  end

  // R3: without a strobe the converter word does not move
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> $stable(word));

  // R4: a strobe transfers the staged bytes
  p_load_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> (word == $past({hi_q, lo_q})));

  // R4: the pulse lasts one cycle unless strobed again
  p_load_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ld_req) |=> !load);
endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic [WORD_W*NUM_CH-1:0] dac_word,
  output logic [NUM_CH-1:0]        dac_load
);
  localparam logic [BYTE_W-1:0] ID_VAL = id_code(NUM_CH);

  logic [NUM_CH-1:0] lo_we, hi_we, ld_req;

  dac_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .ld_req   (ld_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_we  (lo_we[c]),
      .hi_we  (hi_we[c]),
      .ld_req (ld_req[c]),
      .wdata  (bus_wdata),
      .word   (dac_word[WORD_W*c +: WORD_W]),
      .load   (dac_load[c])
    );
  end

  assign bus_rdata = (bus_addr == ID_ADDR) ? ID_VAL : '0;

  // R5: the shared strobe pulses every fitted channel together
  p_both_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == BOTH_ADDR) |=> (&dac_load));
endmodule

// File: tb/dac_stage_regs_tb_top.sv
module dac_stage_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata2, rdata1;
  logic [31:0] word2;
  logic [1:0]  load2;
  logic [15:0] word1;
  logic        load1;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  dac_stage_regs #(.NUM_CH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .dac_word(word2), .dac_load(load2));

  dac_stage_regs #(.NUM_CH(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .dac_word(word1), .dac_load(load1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns one falling edge later
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic t_reset_state;
    chk("R8 word2 in reset", word2, 32'h0);
    chk("R8 load2 in reset", {30'h0, load2}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 word2 after reset", word2, 32'h0);
    chk("R8 word1 after reset", {16'h0, word1}, 32'h0);
    chk("R8 load1 after reset", {31'h0, load1}, 32'h0);
  endtask

  task automatic t_id;
    bus_addr = 8'h00; #1;
    chk("R1 id two-channel", {24'h0, rdata2}, 32'hE3);
    chk("R1 id one-channel", {24'h0, rdata1}, 32'hE2);
    bus_addr = 8'h0D; #1;
    chk("R1 other address reads zero", {24'h0, rdata2}, 32'h0);
    bus_addr = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_hold;
    wr(8'h0D, 8'h34);
    wr(8'h0E, 8'h12);
    chk("R3 staging leaves word2", word2, 32'h0);
    chk("R3 staging leaves word1", {16'h0, word1}, 32'h0);
  endtask

  task automatic t_strobe0;
    wr(8'h0B, 8'h00);
    chk("R4 ch0 word", word2, 32'h0000_1234);
    chk("R4 ch0 pulse", {30'h0, load2}, 32'h1);
    chk("R4 one-ch word", {16'h0, word1}, 32'h1234);
    @(negedge clk);
    chk("R4 pulse one cycle", {30'h0, load2}, 32'h0);
  endtask

  task automatic t_ch1;
    wr(8'h15, 8'hCD);
    wr(8'h16, 8'hAB);
    chk("R2 ch1 staging no change", word2, 32'h0000_1234);
    wr(8'h13, 8'h5A);
    chk("R2 ch1 strobe word", word2, 32'hABCD_1234);
    chk("R2 ch1 strobe pulse", {30'h0, load2}, 32'h2);
    chk("R7 one-ch ignores ch1 strobe pulse", {31'h0, load1}, 32'h0);
    chk("R7 one-ch ignores ch1 strobe word", {16'h0, word1}, 32'h1234);
    wr(8'h0B, 8'hC3);
    chk("R7 one-ch staging not aliased", {16'h0, word1}, 32'h1234);
    chk("R7 one-ch strobe pulse", {31'h0, load1}, 32'h1);
  endtask

  task automatic t_both;
    wr(8'h0D, 8'h00);
    wr(8'h0E, 8'h80);
    wr(8'h15, 8'hFF);
    wr(8'h16, 8'h7F);
    chk("R3 staging both no change", word2, 32'hABCD_1234);
    wr(8'h1B, 8'hFF);
    chk("R5 shared strobe words", word2, 32'h7FFF_8000);
    chk("R5 shared strobe pulses", {30'h0, load2}, 32'h3);
    chk("R7 one-ch shared strobe word", {16'h0, word1}, 32'h8000);
    chk("R7 one-ch shared strobe pulse", {31'h0, load1}, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_restrobe;
    wr(8'h0B, 8'h77);
    chk("R9 restrobe word kept", word2, 32'h7FFF_8000);
    chk("R9 R6 restrobe pulse", {30'h0, load2}, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_collision;
    wr(8'h0D, 8'h11);
    wr(8'h0E, 8'h22);
    wr(8'h0B, 8'hEE);
    chk("R4 collision strobe word", word2, 32'h7FFF_2211);
    chk("R4 collision strobe pulse", {30'h0, load2}, 32'h1);
    wr(8'h0E, 8'h99);  // staging write in the pulse cycle
    chk("R3 collision word kept", word2, 32'h7FFF_2211);
    chk("R4 collision pulse ended", {30'h0, load2}, 32'h0);
    wr(8'h1B, 8'h00);
    chk("R5 R6 shared strobe after collision", word2, 32'h7FFF_9911);
    chk("R7 one-ch after collision", {16'h0, word1}, 32'h9911);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_id();
    t_hold();
    t_strobe0();
    t_ch1();
    t_both();
    t_restrobe();
    t_collision();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule